// File: doc/BRIEF.md
# Instrument Status Byte Reporter

This block builds the 8-bit status byte that a remotely controlled bench instrument reports to its host. It keeps two sticky event registers: a questionable-condition register and a standard event register. Each has an enable mask of the same width. The block also counts the messages waiting in an output queue through push and pop strobes. The status byte summarises these sources at fixed positions. A service-request bit summarises the rest of the byte through its own enable mask.

A host port addresses six locations with a 3-bit select:

| Select | Location | Access |
|---|---|---|
| 0 | status byte | read |
| 1 | questionable event register | read-clear |
| 2 | questionable enable mask | read/write |
| 3 | standard event register | read-clear |
| 4 | standard enable mask | read/write |
| 5 | service-request mask | read/write |

Read data appears on `hostRdata` the cycle after `hostRd`.

A clear-status strobe empties the queue count, zeroes both event registers and pulses `queueFlush` to the queue storage. It does this only when the last received byte was a message terminator, or when no byte has arrived since reset.

Top module: `stsReportTop`

## Requirements
- R1: Status byte bits 2, 1 and 0 always read 0.
- R2: Bit 3 is 1 exactly when some questionable event bit and the same bit of its enable mask (select 2) are both 1.
- R3: Bit 4 is 1 exactly when the queue count is nonzero. `queuePush` alone increments the count, saturating at 2^QCW-1. `queuePop` alone decrements it, and a pop on an empty count is ignored. Push and pop together leave the count unchanged.
- R4: Bit 5 is 1 exactly when some standard event bit and the same bit of its enable mask (select 4) are both 1.
- R5: Bit 6 is the OR of bits 7 and 5..0 ANDed with the service-request mask (select 5). Mask bit 6 is always stored and read as 0.
- R6: Bit 7 follows the `operSum` input.
- R7: An event bit sets on a 0-to-1 transition of its condition input and stays set while the input stays high, until it is cleared. A condition held high does not set the bit again after a clear.
- R8: Reading an event register (select 1 or 3) returns its contents and clears it. A rising condition in the same cycle as the read stays set afterwards.
- R9: A one-bit terminator flag is 1 after reset. A received byte with `rxTerm`=1 sets it, and a received byte with `rxTerm`=0 clears it. `clrReq` is accepted only while the flag is 1, and a rejected `clrReq` changes nothing.
- R10: An accepted clear zeroes both event registers and the queue count, and so drops bit 4. It pulses `queueFlush` high for exactly one cycle and leaves all three masks unchanged.
- R11: A host write with select 2, 4 or 5 loads that mask, and reading the same select returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| qCond | input | QW | questionable condition levels |
| stdCond | input | EW | standard event condition levels |
| operSum | input | 1 | operation summary shown at bit 7 |
| queuePush | input | 1 | one message entered the output queue |
| queuePop | input | 1 | one message left the output queue |
| rxValid | input | 1 | a byte was received from the host |
| rxTerm | input | 1 | the received byte is a message terminator |
| clrReq | input | 1 | clear-status request |
| hostSel | input | 3 | host location select |
| hostRd | input | 1 | host read strobe |
| hostWr | input | 1 | host write strobe |
| hostWdata | input | DW | host write data |
| hostRdata | output | DW | host read data, one cycle after the read |
| statusByte | output | 8 | live status byte |
| queueFlush | output | 1 | one-cycle order to empty the output queue |

## Verification
Full 256-value sweeps of each mask against several event patterns catch a summary built without masking, or with the wrong bit of the byte. A read issued in the same cycle as a fresh condition edge exposes a read-clear that discards the new event. A condition held high across a clear exposes level sensing in place of edge sensing. Pops on an empty count and pushes past the ceiling expose a counter that wraps. A clear sent after a non-terminator byte must leave everything intact, while a clear sent after a terminator must also leave the masks untouched.

// File: rtl/stsPkg.sv
package stsPkg;
  typedef enum logic [2:0] {
    SEL_STB  = 3'd0,
    SEL_QEVT = 3'd1,
    SEL_QEN  = 3'd2,
    SEL_SEVT = 3'd3,
    SEL_SEN  = 3'd4,
    SEL_SRQ  = 3'd5
  } hostSel_e;

  typedef struct packed {
    logic     clrAll;
    logic     rdQ;
    logic     rdS;
    logic     wrQEn;
    logic     wrSEn;
    logic     wrSrq;
    logic     rdEn;
    hostSel_e rdSel;
  } ctrlStrb_t;

  localparam logic [7:0] SRQ_KEEP = 8'hBF;
endpackage

// File: rtl/stsCtrl.sv
module stsCtrl
  import stsPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxValid,
  input  logic      rxTerm,
  input  logic      clrReq,
  input  logic [2:0] hostSel,
  input  logic      hostRd,
  input  logic      hostWr,
  output ctrlStrb_t strb,
  output logic      termFlag
);
  // R9: flag says the previous received byte was a terminator
  always_ff @(posedge clk) begin
    if (!rstN)        termFlag <= 1'b1;
    else if (rxValid) termFlag <= rxTerm;
  end

  always_comb begin
    strb        = '0;
    strb.clrAll = clrReq & termFlag;
    strb.rdEn   = hostRd;
    strb.rdSel  = hostSel_e'(hostSel);
    strb.rdQ    = hostRd & (hostSel == SEL_QEVT);
    strb.rdS    = hostRd & (hostSel == SEL_SEVT);
    strb.wrQEn  = hostWr & (hostSel == SEL_QEN);
    strb.wrSEn  = hostWr & (hostSel == SEL_SEN);
    strb.wrSrq  = hostWr & (hostSel == SEL_SRQ);
  end
endmodule

// File: rtl/stsData.sv
module stsData
  import stsPkg::*;
#(
  parameter int QW  = 8,
  parameter int EW  = 8,
  parameter int QCW = 4,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrb_t     strb,
  input  logic [QW-1:0] qCond,
  input  logic [EW-1:0] stdCond,
  input  logic          operSum,
  input  logic          queuePush,
  input  logic          queuePop,
  input  logic [DW-1:0] hostWdata,
  output logic [DW-1:0] hostRdata,
  output logic [7:0]    statusByte,
  output logic          queueFlush
);
  localparam logic [QCW-1:0] CNT_MAX = '1;

  logic [QW-1:0]  qPrev, qEvt, qEn, qRise;
  logic [EW-1:0]  sPrev, sEvt, sEn, sRise;
  logic [7:0]     srqEn, sbBase;
  logic [QCW-1:0] qCount;
  logic [DW-1:0]  rdMux;
  logic           qss, esb, mav, rqs;

  assign qRise = qCond & ~qPrev;
  assign sRise = stdCond & ~sPrev;

  // R7 R8: sticky edge latch; a clearing cycle still keeps new edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      qPrev <= '0; qEvt <= '0; sPrev <= '0; sEvt <= '0;
    end else begin
      qPrev <= qCond;
      sPrev <= stdCond;
      qEvt  <= ((strb.rdQ || strb.clrAll) ? '0 : qEvt) | qRise;
      sEvt  <= ((strb.rdS || strb.clrAll) ? '0 : sEvt) | sRise;
    end
  end

  // R11 R5: enable masks, untouched by clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      qEn <= '0; sEn <= '0; srqEn <= '0;
    end else begin
      if (strb.wrQEn) qEn   <= hostWdata[QW-1:0];
      if (strb.wrSEn) sEn   <= hostWdata[EW-1:0];
      if (strb.wrSrq) srqEn <= hostWdata[7:0] & SRQ_KEEP;
    end
  end

  // R3 R10: saturating queue occupancy counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCount     <= '0;
      queueFlush <= 1'b0;
    end else begin
      queueFlush <= strb.clrAll;
      if (strb.clrAll)
        qCount <= '0;
      else if (queuePush && !queuePop && qCount != CNT_MAX)
        qCount <= qCount + 1'b1;
      else if (queuePop && !queuePush && qCount != '0)
        qCount <= qCount - 1'b1;
    end
  end

  assign qss    = |(qEvt & qEn);
  assign esb    = |(sEvt & sEn);
  assign mav    = (qCount != '0);
  assign sbBase = {operSum, 1'b0, esb, mav, qss, 3'b000};
  assign rqs    = |(sbBase & srqEn);
  assign statusByte = sbBase | {1'b0, rqs, 6'b0};

  always_comb begin
    case (strb.rdSel)
      SEL_STB:  rdMux = DW'(statusByte);
      SEL_QEVT: rdMux = DW'(qEvt);
      SEL_QEN:  rdMux = DW'(qEn);
      SEL_SEVT: rdMux = DW'(sEvt);
      SEL_SEN:  rdMux = DW'(sEn);
      SEL_SRQ:  rdMux = DW'(srqEn);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          hostRdata <= '0;
    else if (strb.rdEn) hostRdata <= rdMux;
  end
endmodule

// File: rtl/stsReportTop.sv
module stsReportTop
  import stsPkg::*;
#(
  parameter int QW  = 8,
  parameter int EW  = 8,
  parameter int QCW = 4,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [QW-1:0] qCond,
  input  logic [EW-1:0] stdCond,
  input  logic          operSum,
  input  logic          queuePush,
  input  logic          queuePop,
  input  logic          rxValid,
  input  logic          rxTerm,
  input  logic          clrReq,
  input  logic [2:0]    hostSel,
  input  logic          hostRd,
  input  logic          hostWr,
  input  logic [DW-1:0] hostWdata,
  output logic [DW-1:0] hostRdata,
  output logic [7:0]    statusByte,
  output logic          queueFlush
);
  ctrlStrb_t strb;
  logic      termFlag;

  stsCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxTerm(rxTerm),
    .clrReq(clrReq), .hostSel(hostSel), .hostRd(hostRd), .hostWr(hostWr),
    .strb(strb), .termFlag(termFlag)
  );

  stsData #(.QW(QW), .EW(EW), .QCW(QCW), .DW(DW)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .qCond(qCond), .stdCond(stdCond),
    .operSum(operSum), .queuePush(queuePush), .queuePop(queuePop),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .statusByte(statusByte),
    .queueFlush(queueFlush)
  );
endmodule

// File: rtl/stsReportChk.sv
module stsReportChk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] statusByte,
  input logic       queueFlush,
  input logic       queuePush,
  input logic       queuePop,
  input logic       clrReq,
  input logic       termFlag,
  input logic       clrAll,
  input logic       rdQ,
  input logic       wrQEn
);
  a_r1_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[2:0] == 3'b000);

  a_r5_rqs_needs_source: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6] |-> ((statusByte & 8'hBF) != 8'h00));

  a_r3_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    (!statusByte[4] && queuePop && !queuePush && !clrAll) |=> !statusByte[4]);

  a_r3_push_sets: assert property (@(posedge clk) disable iff (!rstN)
    (queuePush && !queuePop && !clrAll) |=> statusByte[4]);

  a_r7_qss_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[3] && !rdQ && !clrAll && !wrQEn) |=> statusByte[3]);

  a_r9_reject: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !termFlag) |=> !queueFlush);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrAll |=> (queueFlush && !statusByte[4]));

  a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (queueFlush && !$past(clrReq)) |-> 1'b0);
endmodule

bind stsReportTop stsReportChk i_chk (
  .clk(clk), .rstN(rstN), .statusByte(statusByte), .queueFlush(queueFlush),
  .queuePush(queuePush), .queuePop(queuePop), .clrReq(clrReq),
  .termFlag(termFlag), .clrAll(strb.clrAll), .rdQ(strb.rdQ),
  .wrQEn(strb.wrQEn)
);

// File: tb/test_stsReportTop.sv
module test_stsReportTop;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] qCond, stdCond, hostWdata, hostRdata, statusByte;
  logic       operSum, queuePush, queuePop, rxValid, rxTerm, clrReq;
  logic       hostRd, hostWr, queueFlush;
  logic [2:0] hostSel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stsReportTop i_stsReportTop (
    .clk(clk), .rstN(rstN), .qCond(qCond), .stdCond(stdCond),
    .operSum(operSum), .queuePush(queuePush), .queuePop(queuePop),
    .rxValid(rxValid), .rxTerm(rxTerm), .clrReq(clrReq), .hostSel(hostSel),
    .hostRd(hostRd), .hostWr(hostWr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .statusByte(statusByte), .queueFlush(queueFlush)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic hWrite(input logic [2:0] sel, input logic [7:0] d);
    hostSel = sel; hostWdata = d; hostWr = 1'b1;
    step();
    hostWr = 1'b0;
  endtask

  task automatic hRead(input logic [2:0] sel, output logic [7:0] d);
    hostSel = sel; hostRd = 1'b1;
    step();
    hostRd = 1'b0;
    d = hostRdata;
  endtask

  task automatic pulseQ(input logic [7:0] p);
    qCond = p; step(); qCond = 8'h00; step();
  endtask

  task automatic pulseS(input logic [7:0] p);
    stdCond = p; step(); stdCond = 8'h00; step();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] d, base, exp;
    logic [7:0] pats [5] = '{8'h01, 8'h80, 8'h5A, 8'hFF, 8'h00};
    rstN = 0; qCond = 0; stdCond = 0; operSum = 0; queuePush = 0; queuePop = 0;
    rxValid = 0; rxTerm = 0; clrReq = 0; hostSel = 0; hostRd = 0; hostWr = 0;
    hostWdata = 0;
    repeat (3) step();
    rstN = 1;
    step();
    chk("R1 reset status byte", statusByte, 8'h00);
    hRead(3'd5, d); chk("R11 reset srq mask", d, 8'h00);

    // R2 R11 R8: questionable sweep
    foreach (pats[i]) begin
      pulseQ(pats[i]);
      for (int en = 0; en < 256; en++) begin
        hWrite(3'd2, 8'(en));
        chk("R2 qss", statusByte[3], |(pats[i] & 8'(en)));
        chk("R1 low bits", statusByte[2:0], 3'b000);
      end
      hRead(3'd2, d); chk("R11 qEn readback", d, 8'hFF);
      hRead(3'd1, d); chk("R8 qEvt read", d, pats[i]);
      hRead(3'd1, d); chk("R8 qEvt cleared", d, 8'h00);
      chk("R2 qss after clear", statusByte[3], 1'b0);
    end

    // R4 standard event sweep
    pulseS(8'h24);
    for (int en = 0; en < 256; en++) begin
      hWrite(3'd4, 8'(en));
      chk("R4 esb", statusByte[5], |(8'h24 & 8'(en)));
    end
    hRead(3'd3, d); chk("R8 sEvt read", d, 8'h24);
    hRead(3'd3, d); chk("R8 sEvt cleared", d, 8'h00);

    // R7 sticky and edge only
    hWrite(3'd2, 8'hFF);
    qCond = 8'h01; step(); step();
    chk("R7 set on edge", statusByte[3], 1'b1);
    hRead(3'd1, d); chk("R7 read value", d, 8'h01);
    step();
    chk("R7 held level no retrigger", statusByte[3], 1'b0);
    qCond = 8'h00; step(); qCond = 8'h01; step();
    chk("R7 new edge sets", statusByte[3], 1'b1);
    qCond = 8'h00;
    // R8 read with coincident edge
    hostSel = 3'd1; hostRd = 1'b1; qCond = 8'h02;
    step();
    hostRd = 1'b0; qCond = 8'h00;
    chk("R8 read returns old", hostRdata, 8'h01);
    hRead(3'd1, d); chk("R8 coincident edge kept", d, 8'h02);

    // R3 queue counter
    queuePush = 1; repeat (3) step(); queuePush = 0;
    chk("R3 mav after push", statusByte[4], 1'b1);
    queuePop = 1; repeat (3) step();
    chk("R3 empty after pops", statusByte[4], 1'b0);
    step(); queuePop = 0;
    chk("R3 pop on empty", statusByte[4], 1'b0);
    queuePush = 1; step(); queuePop = 1; step(); queuePop = 0; queuePush = 0;
    chk("R3 push with pop", statusByte[4], 1'b1);
    queuePop = 1; step(); queuePop = 0;
    chk("R3 back to empty", statusByte[4], 1'b0);
    queuePush = 1; repeat (20) step(); queuePush = 0;
    queuePop = 1; repeat (14) step();
    chk("R3 saturated count minus 14", statusByte[4], 1'b1);
    step(); queuePop = 0;
    chk("R3 saturated count empty at 15", statusByte[4], 1'b0);

    // R6
    operSum = 1; step();
    chk("R6 bit7 set", statusByte[7], 1'b1);
    operSum = 0; step();
    chk("R6 bit7 clear", statusByte[7], 1'b0);

    // R5 srq sweep across source combinations
    hWrite(3'd2, 8'h01); hWrite(3'd4, 8'h01);
    for (int s = 0; s < 16; s++) begin
      operSum = s[0];
      if (s[1]) pulseQ(8'h01); else begin hRead(3'd1, d); end
      if (s[2]) pulseS(8'h01); else begin hRead(3'd3, d); end
      if (s[3]) begin queuePush = 1; step(); queuePush = 0; end
      step();
      base = {s[0], 1'b0, s[2], s[3], s[1], 3'b000};
      for (int m = 0; m < 256; m++) begin
        hWrite(3'd5, 8'(m));
        exp = base | {1'b0, |(base & 8'(m) & 8'hBF), 6'b0};
        chk("R5 status byte", statusByte, exp);
      end
      if (s[3]) begin queuePop = 1; step(); queuePop = 0; end
    end
    hRead(3'd5, d); chk("R5 mask bit6 dropped", d, 8'hBF);
    operSum = 0;

    // R9 R10 clear qualification
    hWrite(3'd2, 8'hFF); hWrite(3'd4, 8'hFF);
    pulseQ(8'h10); pulseS(8'h08);
    queuePush = 1; step(); queuePush = 0;
    rxValid = 1; rxTerm = 0; step(); rxValid = 0;
    clrReq = 1; step(); clrReq = 0;
    chk("R9 rejected no flush", queueFlush, 1'b0);
    chk("R9 rejected keeps byte", statusByte[5:3], 3'b111);
    rxValid = 1; rxTerm = 1; step(); rxValid = 0;
    clrReq = 1; step(); clrReq = 0;
    chk("R10 flush pulse", queueFlush, 1'b1);
    chk("R10 summaries cleared", statusByte[5:3], 3'b000);
    step();
    chk("R10 flush single cycle", queueFlush, 1'b0);
    hRead(3'd1, d); chk("R10 qEvt zero", d, 8'h00);
    hRead(3'd2, d); chk("R10 qEn kept", d, 8'hFF);
    hRead(3'd4, d); chk("R10 sEn kept", d, 8'hFF);
    hRead(3'd5, d); chk("R10 srq kept", d, 8'hBF);
    clrReq = 1; step(); clrReq = 0;
    chk("R9 flag stays after clear", queueFlush, 1'b1);
    hRead(3'd0, d); chk("R1 status read via host", d, 8'h00);

    finishRun();
  end
endmodule